// File: doc/BRIEF.md
# Debug Address and PC Trigger Comparator

This block watches the data-side transfers of a small 32-bit processor and the program counter it reports, and raises a trigger flag when either matches a debug condition. A low and a high address bound, set once by a debug agent, define a window over a 24-bit (16 MB) address space. A two-bit mode picks how each sampled transfer address is judged against that window. The choices are: no trigger, a match on the low bound alone, a match anywhere inside the window with both ends counted, or a match anywhere outside it.

A separate comparator checks the program counter against a breakpoint value. A per-bit mask decides which bits take part in that check. The mask has no meaningful value after reset, so the PC comparator stays disarmed until the breakpoint value and the mask have each been written since the last reset.

All setup goes through one write port that carries a register code and a 32-bit data word. The port models a debug command path and has no read path. The two outputs are registered trigger pulses that a sequencer or halt controller further along can consume.

Top module: `dbg_trig_top`

## Requirements
- R1: While reset is high and after it falls, both trigger outputs are low, the address mode is "off" and the PC comparator is disarmed.
- R2: In equal mode (mode 2'b01), a sampled transfer whose address equals the low bound raises `addr_trig`; any other address does not.
- R3: In inside mode (mode 2'b10), a sampled address with low <= addr <= high raises `addr_trig`; addresses below low or above high do not.
- R4: In outside mode (mode 2'b11), a sampled address with addr < low or addr > high raises `addr_trig`; addresses from low to high inclusive do not.
- R5: In off mode (mode 2'b00), `addr_trig` never rises, whatever the address.
- R6: A transfer is sampled only in a cycle where `bus_valid` is high. A matching address presented with `bus_valid` low produces no trigger. The same rule holds for `pc_valid` and the PC comparator.
- R7: Each trigger output is high for exactly the one cycle after the clock edge that samples the qualifying input. It falls again unless the next cycle also qualifies.
- R8: The PC comparison ignores every bit position where the mask holds 1 and requires equality where it holds 0. `pc_trig` rises when all compared bits match.
- R9: The PC comparator is disarmed and `pc_trig` stays low until both the breakpoint value and the mask have been written since the last reset.
- R10: The register codes are: 8'h07 sets the mode (data bits 1:0), 8'h08 sets the PC breakpoint, 8'h09 sets the PC mask, 8'h0C sets the high bound and 8'h0D sets the low bound. Writes to any other code change nothing. A write takes effect for inputs sampled from the next clock edge on.
- R11: Only data bits 23:0 of a bound, breakpoint or mask write are kept. Bits 31:24 are forced to zero, and all compares use 24 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_code | input | 8 | Register code for the write |
| wr_data | input | 32 | Write data |
| bus_valid | input | 1 | Data-bus transfer present this cycle |
| bus_addr | input | 24 | Transfer address |
| pc_valid | input | 1 | Program counter value present this cycle |
| pc_value | input | 24 | Program counter value |
| addr_trig | output | 1 | Address trigger pulse |
| pc_trig | output | 1 | PC trigger pulse |

## Verification
The hardest situation to reach is a PC comparator that has only part of its setup. A reset with a fresh breakpoint but a stale or missing mask must not arm it. The stimulus writes the breakpoint alone and probes a matching PC. It then adds the mask and probes again. Finally it resets, writes only the mask, and probes a third time. Address bound edges are reached by placing transfers exactly on low, low-1, high and high+1 in both range modes. A bound written with a nonzero upper byte shows that the byte was dropped.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int CODE_W = 8;
    localparam int MODE_W = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [MODE_W-1:0] {
        AM_OFF     = 2'b00,
        AM_EQUAL   = 2'b01,
        AM_INSIDE  = 2'b10,
        AM_OUTSIDE = 2'b11
    } addr_mode_e;

    localparam code_t CODE_MODE    = 8'h07;
    localparam code_t CODE_PC_BP   = 8'h08;
    localparam code_t CODE_PC_MASK = 8'h09;
    localparam code_t CODE_HI      = 8'h0C;
    localparam code_t CODE_LO      = 8'h0D;

    typedef struct packed {
        addr_mode_e mode;
        addr_t      lo;
        addr_t      hi;
    } win_cfg_t;

    typedef struct packed {
        addr_t pc_bp;
        addr_t pc_mask;
        logic  armed;
    } pc_cfg_t;

    // keep the address field of a write word, dropping the upper byte
    function automatic addr_t keep_addr(input data_t d);
        data_t m;
        m = d & {{(DATA_W-ADDR_W){1'b0}}, {ADDR_W{1'b1}}};
        return m[ADDR_W-1:0];
    endfunction

    function automatic logic window_hit(input addr_mode_e mode, input addr_t a,
                                        input addr_t lo, input addr_t hi);
        logic in_win;
        in_win = (a >= lo) && (a <= hi);
        case (mode)
            AM_EQUAL:   return a == lo;
            AM_INSIDE:  return in_win;
            AM_OUTSIDE: return !in_win;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic masked_eq(input addr_t v, input addr_t bp, input addr_t mask);
        return ((v ^ bp) & ~mask) == '0;
    endfunction

endpackage

// File: rtl/dbg_trig_regs.sv
module dbg_trig_regs
    import dbg_trig_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  code_t    wr_code,
    input  data_t    wr_data,
    output win_cfg_t win_cfg,
    output pc_cfg_t  pc_cfg
);

    win_cfg_t win_q;
    addr_t    bp_q;
    addr_t    mask_q;
    logic     bp_seen_q;
    logic     mask_seen_q;
    addr_t    wr_addr;

    assign wr_addr = keep_addr(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q.mode  <= AM_OFF;
            win_q.lo    <= '0;
            win_q.hi    <= '0;
            bp_q        <= '0;
            mask_q      <= '0;
            bp_seen_q   <= 1'b0;
            mask_seen_q <= 1'b0;
        end else if (wr_en) begin
            case (wr_code)
                CODE_MODE:    win_q.mode <= addr_mode_e'(wr_data[MODE_W-1:0]);
                CODE_HI:      win_q.hi   <= wr_addr;
                CODE_LO:      win_q.lo   <= wr_addr;
                CODE_PC_BP: begin
                    bp_q      <= wr_addr;
                    bp_seen_q <= 1'b1;
                end
                CODE_PC_MASK: begin
                    mask_q      <= wr_addr;
                    mask_seen_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign win_cfg        = win_q;
    assign pc_cfg.pc_bp   = bp_q;
    assign pc_cfg.pc_mask = mask_q;
    assign pc_cfg.armed   = bp_seen_q && mask_seen_q;

    // R10
    mode_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_code == CODE_MODE) |=> (win_cfg.mode == addr_mode_e'($past(wr_data[1:0]))));

    // R10
    foreign_code_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_code != CODE_MODE && wr_code != CODE_HI && wr_code != CODE_LO
         && wr_code != CODE_PC_BP && wr_code != CODE_PC_MASK) |=> $stable(win_cfg));

endmodule

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp
    import dbg_trig_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  win_cfg_t cfg,
    input  logic     bus_valid,
    input  addr_t    bus_addr,
    output logic     addr_trig
);

    logic hit;
    logic trig_q;

    assign hit = bus_valid && window_hit(cfg.mode, bus_addr, cfg.lo, cfg.hi);

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= hit;
    end

    assign addr_trig = trig_q;

    // R6
    addr_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_trig) |-> $past(bus_valid));

    // R5
    addr_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == AM_OFF) |=> !addr_trig);

    // R2
    addr_equal_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && cfg.mode == AM_EQUAL && bus_addr == cfg.lo) |=> addr_trig);

    // R7
    addr_pulse_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> !addr_trig);

endmodule

// File: rtl/dbg_pc_cmp.sv
module dbg_pc_cmp
    import dbg_trig_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pc_cfg_t cfg,
    input  logic    pc_valid,
    input  addr_t   pc_value,
    output logic    pc_trig
);

    logic hit;
    logic trig_q;

    assign hit = pc_valid && cfg.armed && masked_eq(pc_value, cfg.pc_bp, cfg.pc_mask);

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= hit;
    end

    assign pc_trig = trig_q;

    // R9
    pc_armed_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.armed |=> !pc_trig);

    // R8
    pc_masked_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_valid && cfg.armed && (((pc_value ^ cfg.pc_bp) & ~cfg.pc_mask) == '0)) |=> pc_trig);

    // R6
    pc_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !pc_valid |=> !pc_trig);

endmodule

// File: rtl/dbg_trig_top.sv
module dbg_trig_top
    import dbg_trig_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_code,
    input  logic [31:0] wr_data,
    input  logic        bus_valid,
    input  logic [23:0] bus_addr,
    input  logic        pc_valid,
    input  logic [23:0] pc_value,
    output logic        addr_trig,
    output logic        pc_trig
);

    win_cfg_t win_cfg;
    pc_cfg_t  pc_cfg;

    dbg_trig_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_code (wr_code),
        .wr_data (wr_data),
        .win_cfg (win_cfg),
        .pc_cfg  (pc_cfg)
    );

    dbg_addr_cmp u_addr_cmp (
        .clk       (clk),
        .rst       (rst),
        .cfg       (win_cfg),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .addr_trig (addr_trig)
    );

    dbg_pc_cmp u_pc_cmp (
        .clk      (clk),
        .rst      (rst),
        .cfg      (pc_cfg),
        .pc_valid (pc_valid),
        .pc_value (pc_value),
        .pc_trig  (pc_trig)
    );

endmodule

// File: tb/dbg_trig_top_bench.sv
module dbg_trig_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_code = '0;
    logic [31:0] wr_data = '0;
    logic        bus_valid = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        pc_valid = 1'b0;
    logic [23:0] pc_value = '0;
    logic        addr_trig;
    logic        pc_trig;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dbg_trig_top u_dbg_trig_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .pc_valid(pc_valid),
        .pc_value(pc_value), .addr_trig(addr_trig), .pc_trig(pc_trig)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 trig low in reset", addr_trig | pc_trig, 1'b0);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] code, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_code = code; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic xfer(input logic [23:0] a, input logic v, input logic exp, input string req);
        @(negedge clk);
        bus_valid = v; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        chk(req, addr_trig, exp);
    endtask

    task automatic pc_probe(input logic [23:0] p, input logic v, input logic exp, input string req);
        @(negedge clk);
        pc_valid = v; pc_value = p;
        @(negedge clk);
        pc_valid = 1'b0;
        chk(req, pc_trig, exp);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 addr_trig after reset", addr_trig, 1'b0);
        chk("R1 pc_trig after reset", pc_trig, 1'b0);
        xfer(24'h000000, 1'b1, 1'b0, "R1 mode off after reset");
        pc_probe(24'h000000, 1'b1, 1'b0, "R1 pc disarmed after reset");
    endtask

    task automatic t_equal();
        wr(8'h0D, 32'h0000_1000);
        wr(8'h07, 32'h1);
        xfer(24'h001000, 1'b1, 1'b1, "R2 equal hit");
        @(negedge clk);
        chk("R7 pulse falls", addr_trig, 1'b0);
        xfer(24'h001001, 1'b1, 1'b0, "R2 equal miss");
        xfer(24'h001000, 1'b0, 1'b0, "R6 no valid no trig");
        // back-to-back samples keep it high, then it drops
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 24'h001000;
        @(negedge clk);
        chk("R7 first of two", addr_trig, 1'b1);
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R7 second of two", addr_trig, 1'b1);
        @(negedge clk);
        chk("R7 drop after run", addr_trig, 1'b0);
    endtask

    task automatic t_upper_byte();
        wr(8'h0D, 32'hAB00_2000);
        xfer(24'h002000, 1'b1, 1'b1, "R11 upper byte dropped");
        xfer(24'h001000, 1'b1, 1'b0, "R10 low bound replaced");
    endtask

    task automatic t_inside();
        wr(8'h0D, 32'h0000_0100);
        wr(8'h0C, 32'h0000_0200);
        wr(8'h07, 32'h2);
        xfer(24'h0000FF, 1'b1, 1'b0, "R3 below low");
        xfer(24'h000100, 1'b1, 1'b1, "R3 at low");
        xfer(24'h000180, 1'b1, 1'b1, "R3 middle");
        xfer(24'h000200, 1'b1, 1'b1, "R3 at high");
        xfer(24'h000201, 1'b1, 1'b0, "R3 above high");
    endtask

    task automatic t_outside();
        wr(8'h07, 32'h3);
        xfer(24'h0000FF, 1'b1, 1'b1, "R4 below low");
        xfer(24'h000100, 1'b1, 1'b0, "R4 at low");
        xfer(24'h000200, 1'b1, 1'b0, "R4 at high");
        xfer(24'h000201, 1'b1, 1'b1, "R4 above high");
        xfer(24'hFFFFFF, 1'b1, 1'b1, "R4 top of space");
    endtask

    task automatic t_foreign_codes();
        wr(8'h0E, 32'h0);
        wr(8'h06, 32'h0);
        wr(8'h0A, 32'h0);
        xfer(24'h0000FF, 1'b1, 1'b1, "R10 foreign codes ignored");
    endtask

    task automatic t_off();
        wr(8'h07, 32'h0);
        xfer(24'h0000FF, 1'b1, 1'b0, "R5 off below");
        xfer(24'h000100, 1'b1, 1'b0, "R5 off at low");
    endtask

    task automatic t_pc();
        wr(8'h08, 32'h0000_ABCD);
        pc_probe(24'h00ABCD, 1'b1, 1'b0, "R9 bp only stays disarmed");
        wr(8'h09, 32'h0000_0000);
        pc_probe(24'h00ABCD, 1'b1, 1'b1, "R8 full compare hit");
        pc_probe(24'h00ABCE, 1'b1, 1'b0, "R8 full compare miss");
        pc_probe(24'h00ABCD, 1'b0, 1'b0, "R6 pc_valid low");
        wr(8'h09, 32'h0000_00FF);
        pc_probe(24'h00AB00, 1'b1, 1'b1, "R8 masked low byte hit");
        pc_probe(24'h00AC00, 1'b1, 1'b0, "R8 unmasked bit miss");
        do_reset();
        wr(8'h09, 32'h0000_0000);
        pc_probe(24'h000000, 1'b1, 1'b0, "R9 mask only stays disarmed");
        wr(8'h08, 32'h5500_0010);
        pc_probe(24'h000010, 1'b1, 1'b1, "R11 bp upper byte dropped");
    endtask

    initial begin
        t_reset();
        t_equal();
        t_upper_byte();
        t_inside();
        t_outside();
        t_foreign_codes();
        t_off();
        t_pc();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule